// File: doc/BRIEF.md
# Halt and Idle Power-Mode Sequencer

This block decides when the core of a small two-clock microcontroller may run. Software stops the core through a control-port write. Setting the halt bit parks the core until an outside event arrives. Setting the idle bit parks it for a programmed stretch of slow-clock time. The block gates the core clock enable, moves the timebase between the slow oscillator and the divided fast oscillator, and enforces a start-up wait that cannot be skipped after every wake from halt.

Leaving halt through a wake-up event starts a countdown of 256 instruction cycles. Each instruction cycle is five fast-clock periods. The countdown advances only while the fast oscillator is reported as stable. An external active-low reset ends either low-power state at once. Idle ends by itself once its slow-clock budget has elapsed. The wake-up and external reset lines are asynchronous and pass through two-flop synchronizers.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the synchronous reset `rst`, core_en is 1, and halt_st, idle_st and tmr_clk_sel are all 0.
- R2: A write with bit 7 of ctl_wdata set, while halt_dis is 0 and the core runs, drops core_en and raises halt_st at the middle phase of the following instruction cycle, no more than 8 clocks after the write.
- R3: When halt_dis is 1, a halt write has no effect: core_en stays 1 and halt_st stays 0.
- R4: Without a wake-up or an external reset, halt continues for any length of time: core_en stays 0, halt_st stays 1, tmr_clk_sel stays 0.
- R5: A wake-up event during halt sets tmr_clk_sel to 1 (1 means divided fast clock, 0 means slow clock). core_en returns 1280 to 1290 clocks after the wake-up input rises, which is 256 instruction cycles of 5 clocks.
- R6: While osc_ok is 0 the start-up countdown is frozen, so each cycle of osc_ok low lengthens the wait by one clock.
- R7: When the countdown finishes, core_en becomes 1 and both halt_st and tmr_clk_sel return to 0.
- R8: Pulling ext_rst_n low during halt returns the block to running within 4 clocks, with no countdown.
- R9: A write with bit 6 set enters idle (idle_st 1, core_en 0). Bits 5:4 pick an idle length of 4096, 8192, 16384 or 32768 slow_tick pulses. When that count is reached, the block returns to running on its own.
- R10: A wake-up event while the core runs is ignored: core_en stays 1 and tmr_clk_sel stays 0.
- R11: A halt write made during the start-up countdown is discarded and does not halt the core after the countdown ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 8 | Control-port write data (bit 7 halt, bit 6 idle, bits 5:4 idle length) |
| halt_dis | input | 1 | Option bit that blocks software halt |
| wake_evt | input | 1 | Asynchronous wake-up event |
| ext_rst_n | input | 1 | Asynchronous external reset, active low |
| osc_ok | input | 1 | Fast-oscillator amplitude qualifier |
| slow_tick | input | 1 | One-clock pulse per slow-oscillator period |
| core_en | output | 1 | Core clock enable |
| halt_st | output | 1 | Halt state, which includes the start-up wait |
| idle_st | output | 1 | Idle state |
| tmr_clk_sel | output | 1 | Timebase select: 1 means divided fast clock, 0 means slow clock |

## Verification
The halt path is run four ways:
- with a plain wake-up;
- with osc_ok dropped part way through the countdown;
- with a halt write placed inside the countdown;
- with an external reset instead of a wake-up.

Comparing the release latencies of the first two runs shows whether the countdown counts qualified cycles or raw clocks. The third run shows whether requests are properly gated while the countdown runs. Idle is run with three length codes, so a wrong shift or a swapped select shows up as a doubled or halved duration. Halt writes under halt_dis and wake-ups while running confirm that those inputs leave the outputs untouched.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_START = 2'd2,
        ST_IDLE  = 2'd3
    } pmode_e;

    localparam int HALT_BIT = 7;
    localparam int IDLE_BIT = 6;
    localparam int SEL_LSB  = 4;

    typedef struct packed {
        logic halt;
        logic idle;
    } pend_t;

    // Final count value for an idle stretch of base << sel slow pulses
    function automatic int idle_last(input int base, input int sel);
        return (base << sel) - 1;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
`timescale 1ns/1ps
module pwr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_inst_div.sv
`timescale 1ns/1ps
module pwr_inst_div #(
    parameter int DIV = 5,
    parameter int MID = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic mid_tick,
    output logic end_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || clr)                       phase <= '0;
        else if (en) begin
            if (phase == PW'(DIV - 1))        phase <= '0;
            else                              phase <= phase + 1'b1;
        end
    end

    assign mid_tick = en && (phase == PW'(MID));
    assign end_tick = en && (phase == PW'(DIV - 1));
endmodule

// File: rtl/pwr_startup_cnt.sv
`timescale 1ns/1ps
module pwr_startup_cnt #(
    parameter int LOAD = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LOAD) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                           cnt <= '0;
        else if (load)                     cnt <= CW'(LOAD);
        else if (tick && cnt != '0)        cnt <= cnt - 1'b1;
    end

    assign done = tick && (cnt == CW'(1));
endmodule

// File: rtl/pwr_idle_tmr.sv
`timescale 1ns/1ps
module pwr_idle_tmr
    import pwr_seq_pkg::*;
#(
    parameter int BASE  = 4096,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             slow_tick,
    output logic             done
);
    localparam int CW = $clog2(BASE) + (1 << SEL_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = CW'(idle_last(BASE, int'(sel)));

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (slow_tick)  cnt <= cnt + 1'b1;
    end

    assign done = run && slow_tick && (cnt == last);
endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int DIV         = 5,
    parameter int MID_PHASE   = 2,
    parameter int START_LOAD  = 256,
    parameter int IDLE_BASE   = 4096,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       halt_dis,
    input  logic       wake_evt,
    input  logic       ext_rst_n,
    input  logic       osc_ok,
    input  logic       slow_tick,
    output logic       core_en,
    output logic       halt_st,
    output logic       idle_st,
    output logic       tmr_clk_sel
);
    pmode_e            state, state_nx;
    pend_t             pend;
    logic [SEL_W-1:0]  idle_sel;
    logic              wake_s, ext_rst_s, hard_rst;
    logic              div_en, div_clr, mid_tick, end_tick;
    logic              cnt_load, cnt_done, idle_done;
    logic              wr_halt, wr_idle;

    pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
        .clk(clk), .rst(rst), .d(wake_evt), .q(wake_s)
    );
    pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_xrst_sync (
        .clk(clk), .rst(rst), .d(ext_rst_n), .q(ext_rst_s)
    );

    assign hard_rst = rst || !ext_rst_s;

    // Instruction-cycle divider: free in run, qualified by osc_ok in start-up
    assign div_en  = (state == ST_RUN) || ((state == ST_START) && osc_ok);
    assign div_clr = (state == ST_HALT) || (state == ST_IDLE);

    pwr_inst_div #(.DIV(DIV), .MID(MID_PHASE)) u_div (
        .clk(clk), .rst(hard_rst), .clr(div_clr), .en(div_en),
        .mid_tick(mid_tick), .end_tick(end_tick)
    );

    assign cnt_load = (state == ST_HALT) && wake_s;

    pwr_startup_cnt #(.LOAD(START_LOAD)) u_start (
        .clk(clk), .rst(hard_rst), .load(cnt_load),
        .tick(end_tick && (state == ST_START)), .done(cnt_done)
    );

    pwr_idle_tmr #(.BASE(IDLE_BASE), .SEL_W(SEL_W)) u_idle (
        .clk(clk), .rst(hard_rst), .run(state == ST_IDLE), .sel(idle_sel),
        .slow_tick(slow_tick), .done(idle_done)
    );

    // Requests are taken only while the core runs
    assign wr_halt = ctl_wr && ctl_wdata[HALT_BIT] && !halt_dis && (state == ST_RUN);
    assign wr_idle = ctl_wr && ctl_wdata[IDLE_BIT] && (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            pend     <= '0;
            idle_sel <= '0;
        end else if (state != ST_RUN || state_nx != ST_RUN) begin
            pend <= '0;
        end else begin
            if (wr_halt)  pend.halt <= 1'b1;
            if (halt_dis) pend.halt <= 1'b0;
            if (wr_idle) begin
                pend.idle <= 1'b1;
                idle_sel  <= ctl_wdata[SEL_LSB +: SEL_W];
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (pend.halt && !halt_dis && mid_tick) state_nx = ST_HALT;
                else if (pend.idle && mid_tick)         state_nx = ST_IDLE;
            end
            ST_HALT:  if (wake_s)    state_nx = ST_START;
            ST_START: if (cnt_done)  state_nx = ST_RUN;
            ST_IDLE:  if (idle_done) state_nx = ST_RUN;
            default:                 state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_rst) state <= ST_RUN;
        else          state <= state_nx;
    end

    assign core_en     = (state == ST_RUN);
    assign halt_st     = (state == ST_HALT) || (state == ST_START);
    assign idle_st     = (state == ST_IDLE);
    assign tmr_clk_sel = (state == ST_START);
endmodule

// File: rtl/pwr_mode_seq_chk.sv
`timescale 1ns/1ps
module pwr_mode_seq_chk #(
    parameter int DIV        = 5,
    parameter int START_LOAD = 256
) (
    input logic clk,
    input logic rst,
    input logic halt_dis,
    input logic osc_ok,
    input logic ext_rst_s,
    input logic core_en,
    input logic halt_st,
    input logic idle_st,
    input logic tmr_clk_sel
);
    int qcnt;

    always_ff @(posedge clk) begin
        if (rst || !tmr_clk_sel) qcnt <= 0;
        else if (osc_ok)         qcnt <= qcnt + 1;
    end

    p_halt_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        halt_dis |=> !$rose(halt_st));

    p_start_enter_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_clk_sel) |-> (halt_st && !core_en));

    p_full_wait_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_en) && $past(tmr_clk_sel)) |-> (qcnt >= DIV * START_LOAD));

    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (tmr_clk_sel && !osc_ok && ext_rst_s) |=> !core_en);

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tmr_clk_sel) |-> (core_en && !halt_st));

    p_ext_rst_r8: assert property (@(posedge clk) disable iff (rst)
        !ext_rst_s |=> (core_en && !halt_st && !idle_st));

    p_idle_slow_r9: assert property (@(posedge clk) disable iff (rst)
        idle_st |-> (!tmr_clk_sel && !core_en && !halt_st));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.DIV(DIV), .START_LOAD(START_LOAD)) u_chk (
    .clk(clk), .rst(rst), .halt_dis(halt_dis), .osc_ok(osc_ok),
    .ext_rst_s(ext_rst_s), .core_en(core_en), .halt_st(halt_st),
    .idle_st(idle_st), .tmr_clk_sel(tmr_clk_sel)
);

// File: tb/test_pwr_mode_seq.sv
`timescale 1ns/1ps
module test_pwr_mode_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       halt_dis = 1'b0;
    logic       wake_evt = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       osc_ok = 1'b1;
    logic       slow_tick = 1'b0;
    logic       core_en, halt_st, idle_st, tmr_clk_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;                       // 250 MHz
    always @(negedge clk) slow_tick <= ~slow_tick;

    pwr_mode_seq i_pwr_mode_seq (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .halt_dis(halt_dis), .wake_evt(wake_evt), .ext_rst_n(ext_rst_n),
        .osc_ok(osc_ok), .slow_tick(slow_tick), .core_en(core_en),
        .halt_st(halt_st), .idle_st(idle_st), .tmr_clk_sel(tmr_clk_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 8'h00;
    endtask

    task automatic enter_halt(output int n);
        write_ctl(8'h80);
        n = 0;
        while (core_en && n < 20) begin @(negedge clk); n++; end
    endtask

    // Raise wake-up; optionally drop osc_ok or write halt mid-countdown
    task automatic wake_run(input int stall, input bit late_wr, output int n, output int sel_mid);
        wake_evt = 1'b1;
        n = 0; sel_mid = 0;
        while (!core_en && n < 3000) begin
            @(negedge clk); n++;
            if (n == 600) sel_mid = int'(tmr_clk_sel);
            if (n == 100 && stall > 0) osc_ok = 1'b0;
            if (n == 100 + stall) osc_ok = 1'b1;
            if (n == 100 && late_wr) begin ctl_wr = 1'b1; ctl_wdata = 8'h80; end
            if (n == 101) begin ctl_wr = 1'b0; ctl_wdata = 8'h00; end
        end
        wake_evt = 1'b0; osc_ok = 1'b1; ctl_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 core_en", int'(core_en), 1);
        chk("R1 halt_st", int'(halt_st), 0);
        chk("R1 idle_st", int'(idle_st), 0);
        chk("R1 tmr_clk_sel", int'(tmr_clk_sel), 0);
    endtask

    task automatic t_halt_dis;
        halt_dis = 1'b1;
        write_ctl(8'h80);
        cyc(12);
        chk("R3 core_en", int'(core_en), 1);
        chk("R3 halt_st", int'(halt_st), 0);
        halt_dis = 1'b0;
        cyc(4);
    endtask

    task automatic t_halt_wake;
        int n, s;
        enter_halt(n);
        chk_rng("R2 entry delay", n, 0, 7);
        chk("R2 halt_st", int'(halt_st), 1);
        cyc(3000);
        chk("R4 core_en", int'(core_en), 0);
        chk("R4 halt_st", int'(halt_st), 1);
        chk("R4 tmr_clk_sel", int'(tmr_clk_sel), 0);
        wake_run(0, 1'b0, n, s);
        chk("R5 tmr_clk_sel in countdown", s, 1);
        chk_rng("R5 release delay", n, 1280, 1290);
        chk("R7 halt_st", int'(halt_st), 0);
        chk("R7 tmr_clk_sel", int'(tmr_clk_sel), 0);
        chk("R7 core_en", int'(core_en), 1);
        cyc(4);
    endtask

    task automatic t_stall;
        int n, s;
        enter_halt(n);
        cyc(10);
        wake_run(100, 1'b0, n, s);
        chk_rng("R6 stalled release delay", n, 1380, 1390);
        cyc(4);
    endtask

    task automatic t_wake_running;
        wake_evt = 1'b1;
        cyc(10);
        chk("R10 core_en", int'(core_en), 1);
        chk("R10 tmr_clk_sel", int'(tmr_clk_sel), 0);
        wake_evt = 1'b0;
        cyc(4);
    endtask

    task automatic t_halt_in_start;
        int n, s;
        enter_halt(n);
        cyc(10);
        wake_run(0, 1'b1, n, s);
        cyc(20);
        chk("R11 core_en", int'(core_en), 1);
        chk("R11 halt_st", int'(halt_st), 0);
    endtask

    task automatic t_ext_reset;
        int n;
        enter_halt(n);
        cyc(10);
        ext_rst_n = 1'b0;
        n = 0;
        while (!core_en && n < 10) begin @(negedge clk); n++; end
        chk_rng("R8 reset exit delay", n, 1, 4);
        chk("R8 tmr_clk_sel", int'(tmr_clk_sel), 0);
        chk("R8 halt_st", int'(halt_st), 0);
        ext_rst_n = 1'b1;
        cyc(6);
    endtask

    task automatic t_idle(input int sel);
        int n, m, len;
        len = 4096 << sel;
        write_ctl(8'h40 | 8'(sel << 4));
        n = 0;
        while (!idle_st && n < 20) begin @(negedge clk); n++; end
        chk("R9 idle_st", int'(idle_st), 1);
        chk("R9 core_en in idle", int'(core_en), 0);
        m = 0;
        while (idle_st && m < 70000) begin @(negedge clk); m++; end
        chk_rng($sformatf("R9 idle length sel=%0d", sel), m, 2 * len - 6, 2 * len + 6);
        chk("R9 core_en after idle", int'(core_en), 1);
        cyc(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(4);
        t_reset();
        t_halt_dis();
        t_halt_wake();
        t_stall();
        t_wake_running();
        t_halt_in_start();
        t_ext_reset();
        t_idle(0);
        t_idle(1);
        t_idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule